// File: doc/BRIEF.md
# Serial Transmit Engine with Holding Register

This block is the sending side of an asynchronous serial port whose bit timing comes from a 16x oversampling tick. A processor writes one byte into a single-entry holding register. When the shift stage is free, the byte moves into it. The shift stage then sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then the stop bits. The stop bits are high.

A 7-bit line control word sets the frame. The shift stage captures this word at the moment it loads a byte, so the whole frame keeps one format. The break bit is the exception: it acts on the output at once and forces the line low. Two flags report progress. One shows that the holding register can take a new byte. The other shows that the holding register and the shift stage are both empty.

Top module: `sertx_top`

## Requirements
- R1: While reset is asserted and after it is released, `tx` is 1, `hold_empty` is 1 and `xmit_empty` is 1.
- R2: A frame starts with one low bit, followed by the data bits least significant first. The count of data bits is set by `line_ctl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8.
- R3: When `line_ctl[3]`=1 and `line_ctl[5]`=0, a parity bit follows the data. With `line_ctl[4]`=1 it makes the number of ones even; with `line_ctl[4]`=0 it makes it odd.
- R4: When `line_ctl[3]`=1 and `line_ctl[5]`=1, the parity bit is a constant. It is 1 when `line_ctl[4]`=0 and 0 when `line_ctl[4]`=1.
- R5: Start, data and parity bits each last 16 ticks. With `line_ctl[2]`=0 the stop time is 16 ticks. With `line_ctl[2]`=1 it is 24 ticks for a 5-bit word and 32 ticks for any other length.
- R6: While `line_ctl[6]`=1, `tx` is 0, whether the line is idle or a frame is being sent.
- R7: A write clears `hold_empty` on the next clock. `hold_empty` returns to 1 on the clock in which the byte is loaded into the shift stage. It stays 0 while a frame in progress keeps the shift stage busy.
- R8: `xmit_empty` is 1 only when the holding register and the shift stage are both empty. A byte waiting in the holding register starts its frame on the same tick that ends the previous stop time, with no idle gap between the frames.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tick16 | input | 1 | One-cycle enable, pulsing at 16 times the baud rate |
| line_ctl | input | 7 | Frame control: [1:0] length, [2] stop select, [3] parity on, [4] even, [5] forced parity, [6] break |
| tx | output | 1 | Serial output, high when idle |
| hold_empty | output | 1 | Holding register can accept a byte |
| xmit_empty | output | 1 | Holding register and shift stage both empty |

## Verification
The bench sends each supported word length, every parity mode and every stop-bit selection. It counts ticks from the falling edge of each start bit to the end of the frame. A design that picks the wrong stop length for the 5-bit case would miss the 24-tick total by half a bit. A design that swaps the two forced-parity constants, or the even and odd senses, would show a wrong bit at the centre of the parity bit. For back-to-back frames, the bench requires the next start bit on the exact tick where the previous stop time ends. A design that inserted an idle gap, or that cleared the holding flag before the load, would fail either the frame-length check or the flag check. Break is applied both while the line is idle and in the middle of a frame, to catch a break that only acts between frames.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Field order follows the control word, bit 6 down to bit 0.
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stop2;
    logic [1:0] wlen;
  } frame_ctl_t;

endpackage

// File: rtl/sertx_rstsync.sv
`timescale 1ns/1ps
module sertx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] q
);

  logic          full_d;
  logic [DW-1:0] q_d;

  always_comb begin
    full_d = wr | (full & ~take);
    q_d    = wr ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      full <= full_d;
      q    <= q_d;
    end
  end

  assert_wr_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> full);
  assert_take_clears_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr) |=> !full);

endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_q,
  input  logic [1:0]    wlen,
  input  logic          stop2,
  input  logic          pen,
  input  logic          even,
  input  logic          stick,
  output logic          take,
  output logic          line,
  output logic          idle
);

  localparam int CW = $clog2(2 * OSR);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] BIT_LAST   = CW'(OSR - 1);
  localparam logic [CW-1:0] STOP1_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] STOPH_LAST = CW'(OSR + OSR / 2 - 1);
  localparam logic [CW-1:0] STOP2_LAST = CW'(2 * OSR - 1);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, stop_last_q, stop_last_d;
  logic [IW-1:0] bidx_q, bidx_d, last_q, last_d;
  logic [DW-1:0] sreg_q, sreg_d, dmask, dsel;
  logic          pen_q, pen_d, pbit_q, pbit_d, pcalc, stop_done;

  always_comb begin
    dmask = {DW{1'b1}} >> (2'd3 - wlen);
    dsel  = hold_q & dmask;
    pcalc = stick ? ~even : (even ? ^dsel : ~(^dsel));
  end

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    bidx_d      = bidx_q;
    last_d      = last_q;
    sreg_d      = sreg_q;
    pen_d       = pen_q;
    pbit_d      = pbit_q;
    stop_last_d = stop_last_q;
    stop_done   = (state_q == ST_STOP) && tick && (cnt_q == stop_last_q);
    take        = 1'b0;
    unique case (state_q)
      ST_START: if (tick) begin
        if (cnt_q == BIT_LAST) begin
          cnt_d   = '0;
          bidx_d  = '0;
          state_d = ST_DATA;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_DATA: if (tick) begin
        if (cnt_q == BIT_LAST) begin
          cnt_d  = '0;
          sreg_d = sreg_q >> 1;
          if (bidx_q == last_q) state_d = pen_q ? ST_PAR : ST_STOP;
          else                  bidx_d  = bidx_q + IW'(1);
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_PAR: if (tick) begin
        if (cnt_q == BIT_LAST) begin
          cnt_d   = '0;
          state_d = ST_STOP;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_STOP: if (tick) begin
        if (stop_done) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else cnt_d = cnt_q + CW'(1);
      end
      default: ;
    endcase
    // Load from the holding register when idle or exactly as the stop time ends.
    if (hold_full && (state_q == ST_IDLE || stop_done)) begin
      take    = 1'b1;
      state_d = ST_START;
      cnt_d   = '0;
      sreg_d  = hold_q;
      last_d  = IW'(DW - 4) + IW'(wlen);
      pen_d   = pen;
      pbit_d  = pcalc;
      if (!stop2)          stop_last_d = STOP1_LAST;
      else if (wlen == 2'd0) stop_last_d = STOPH_LAST;
      else                 stop_last_d = STOP2_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bidx_q      <= '0;
      last_q      <= '0;
      sreg_q      <= '0;
      pen_q       <= 1'b0;
      pbit_q      <= 1'b0;
      stop_last_q <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      bidx_q      <= bidx_d;
      last_q      <= last_d;
      sreg_q      <= sreg_d;
      pen_q       <= pen_d;
      pbit_q      <= pbit_d;
      stop_last_q <= stop_last_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sreg_q[0];
      ST_PAR:   line = pbit_q;
      default:  line = 1'b1;
    endcase
  end

  assign idle = (state_q == ST_IDLE);

  assert_start_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (state_q == ST_START && cnt_q == '0));
  assert_bit_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START || state_q == ST_DATA || state_q == ST_PAR) |-> (cnt_q < CW'(OSR)));

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          tick16,
  input  logic [6:0]    line_ctl,
  output logic          tx,
  output logic          hold_empty,
  output logic          xmit_empty
);

  logic          rst_s_n, full, take, line, idle;
  logic [DW-1:0] hold_q;
  frame_ctl_t    ctl_s;

  assign ctl_s = frame_ctl_t'(line_ctl);

  sertx_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sertx_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr    (wr_stb),
    .wdata (wr_data),
    .take  (take),
    .full  (full),
    .q     (hold_q)
  );

  sertx_shift #(.DW(DW), .OSR(OSR)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick      (tick16),
    .hold_full (full),
    .hold_q    (hold_q),
    .wlen      (ctl_s.wlen),
    .stop2     (ctl_s.stop2),
    .pen       (ctl_s.pen),
    .even      (ctl_s.even),
    .stick     (ctl_s.stick),
    .take      (take),
    .line      (line),
    .idle      (idle)
  );

  assign tx         = line & ~ctl_s.brk;
  assign hold_empty = ~full;
  assign xmit_empty = idle & ~full;

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xmit_empty && !ctl_s.brk) |-> tx);
  assert_empty_implies_hold_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    xmit_empty |-> hold_empty);

endmodule

// File: tb/sertx_top_tb.sv
`timescale 1ns/1ps
module sertx_top_tb;

  typedef struct {
    logic [7:0] d;
    logic [6:0] c;
  } exp_t;

  logic       clk, rst_n, wr_stb, tick16;
  logic [7:0] wr_data;
  logic [6:0] line_ctl;
  logic       tx, hold_empty, xmit_empty;

  int   checks = 0;
  int   errors = 0;
  int   nticks = 0;
  bit   mon_en = 1;
  exp_t exp_q[$];

  sertx_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .tick16     (tick16),
    .line_ctl   (line_ctl),
    .tx         (tx),
    .hold_empty (hold_empty),
    .xmit_empty (xmit_empty)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  initial forever begin
    @(posedge clk);
    if (tick16) nticks = nticks + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int ndata(input logic [6:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic logic exp_bit(input exp_t e, input int k);
    int nd, ones;
    nd = ndata(e.c);
    if (k == 0) return 1'b0;
    if (k <= nd) return e.d[k-1];
    if (e.c[3] && k == nd + 1) begin
      if (e.c[5]) return ~e.c[4];
      ones = 0;
      for (int i = 0; i < nd; i++) ones += int'(e.d[i]);
      return e.c[4] ? logic'(ones % 2) : ~logic'(ones % 2);
    end
    return 1'b1;
  endfunction

  // Monitor: pops expected frames and checks bit centres and total length.
  initial begin
    bit   active;
    int   t0, nb, total, k, nd;
    exp_t e;
    logic prev_tx;
    active  = 0;
    prev_tx = 1'b1;
    t0 = 0; nb = 0; total = 0; k = 0; nd = 0;
    forever begin
      @(negedge clk);
      if (!mon_en || !rst_n) begin
        active  = 0;
        prev_tx = tx;
      end else begin
        if (active) begin
          int el;
          string tag;
          el = nticks - t0;
          if (k <= nb && el == 16 * k + 8) begin
            if (k == nb)                 tag = "R5 stop bit";
            else if (k == nd + 1)        tag = e.c[5] ? "R4 forced parity" : "R3 parity";
            else                         tag = "R2 start/data bit";
            chk(tx == exp_bit(e, k), tag, int'(tx), int'(exp_bit(e, k)));
            k++;
          end
          if (el >= 16 * nb && (xmit_empty || !tx)) begin
            chk(el == total, "R5 frame length in ticks", el, total);
            chk(k == nb + 1, "R5 all bit centres seen", k, nb + 1);
            active = 0;
          end else if (el > total + 16) begin
            chk(0, "R5 frame did not end", el, total);
            active = 0;
          end
        end
        if (!active && prev_tx && !tx) begin
          if (exp_q.size() == 0) chk(0, "R2 unexpected start bit", 0, 1);
          else begin
            e      = exp_q.pop_front();
            nd     = ndata(e.c);
            nb     = 1 + nd + int'(e.c[3]);
            total  = 16 * nb + (e.c[2] ? ((nd == 5) ? 24 : 32) : 16);
            t0     = nticks;
            k      = 0;
            active = 1;
          end
        end
        prev_tx = tx;
      end
    end
  end

  // Driver: pushes the expected frame and writes the holding register.
  task automatic send(input logic [7:0] d, input logic [6:0] c);
    exp_t e;
    while (!hold_empty) @(negedge clk);
    line_ctl = c;
    e.d = d;
    e.c = c;
    exp_q.push_back(e);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic wait_idle();
    while (!xmit_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    wr_stb   = 1'b0;
    wr_data  = 8'h00;
    line_ctl = 7'h03;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1 && hold_empty && xmit_empty, "R1 outputs during reset",
        int'({tx, hold_empty, xmit_empty}), 7);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1 && hold_empty && xmit_empty, "R1 outputs after reset",
        int'({tx, hold_empty, xmit_empty}), 7);

    // R7/R8 flag timing around a single write while idle.
    send(8'hA5, 7'h03);
    chk(!hold_empty, "R7 hold flag clears after write", int'(hold_empty), 0);
    chk(!xmit_empty, "R8 xmit flag clears after write", int'(xmit_empty), 0);
    @(negedge clk);
    chk(hold_empty, "R7 hold flag set on load", int'(hold_empty), 1);
    chk(!xmit_empty, "R8 xmit flag low while shifting", int'(xmit_empty), 0);
    wait_idle();

    // Word lengths, stop selections and parity modes.
    send(8'h16, 7'h04);  wait_idle();  // R5 5-bit, 1.5 stop
    send(8'h2D, 7'h05);  wait_idle();  // R5 6-bit, 2 stop
    send(8'h00, 7'h00);  wait_idle();  // R2 5-bit, 1 stop
    send(8'h53, 7'h1A);  wait_idle();  // R3 7-bit even
    send(8'hC1, 7'h0B);  wait_idle();  // R3 8-bit odd
    send(8'hFF, 7'h0E);  wait_idle();  // R3 7-bit odd, 2 stop
    send(8'h3C, 7'h2B);  wait_idle();  // R4 forced 1
    send(8'h81, 7'h3B);  wait_idle();  // R4 forced 0
    send(8'h1F, 7'h3C);  wait_idle();  // R4 forced 0, 5-bit, 1.5 stop

    // R8 back-to-back frames; R7 holding byte waits while shifting.
    send(8'h6E, 7'h03);
    send(8'h91, 7'h03);
    chk(!hold_empty, "R7 second byte held", int'(hold_empty), 0);
    repeat (40) @(negedge clk);
    chk(!hold_empty, "R7 hold flag stays low while busy", int'(hold_empty), 0);
    chk(!xmit_empty, "R8 xmit flag low with both full", int'(xmit_empty), 0);
    send(8'h4A, 7'h03);
    wait_idle();
    chk(exp_q.size() == 0, "R8 all queued frames sent", exp_q.size(), 0);

    // R6 break while idle and during a frame.
    mon_en = 0;
    line_ctl = 7'h43;
    @(negedge clk);
    chk(tx == 1'b0, "R6 break holds line low when idle", int'(tx), 0);
    line_ctl = 7'h03;
    @(negedge clk);
    chk(tx == 1'b1, "R6 line high after break release", int'(tx), 1);
    send(8'hFF, 7'h03);
    repeat (10) @(negedge clk);
    line_ctl = 7'h43;
    begin
      bit low_all;
      low_all = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (tx) low_all = 0;
      end
      chk(low_all, "R6 break holds line low mid-frame", int'(low_all), 1);
    end
    line_ctl = 7'h03;
    wait_idle();
    exp_q.delete();
    chk(tx == 1'b1 && xmit_empty, "R6 idle line high after break frame",
        int'({tx, xmit_empty}), 3);
    mon_en = 1;

    // Second reset check.
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx == 1'b1 && hold_empty && xmit_empty, "R1 outputs on reset reassert",
        int'({tx, hold_empty, xmit_empty}), 7);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule